// File: doc/BRIEF.md
# March Algorithm RAM Self-Test Controller

This controller drives a synchronous single-port RAM through one of three March algorithms. It generates every address, write word and read for the test. It checks each word read back against the value the algorithm expects at that point. One mismatch is enough to fail the run. The controller then holds the address and the element number of the first mismatch so that the failure can be located.

A run begins with a one-cycle start pulse that arrives while the controller is idle. The algorithm code is taken in the same cycle. The controller then issues one memory operation on every clock. Each element walks the whole address space in its own direction, and the operations inside an element are applied to each address before the controller moves to the next address. A read returns its data one cycle after it is issued, so the compare stage is delayed by one cycle to match. Once the last compare has been made, the controller raises a done level and returns to idle. The pass/fail result stays valid until the next run is accepted.

The two-bit background variant adds alternating-bit words to the plain all-zeros and all-ones words. This exposes faults between neighbouring bits of the same word that solid backgrounds cannot reveal.

Top module: `mbist_march_ctrl`

## Requirements
- R1: `start_i` and `algo_sel_i` are sampled only when `busy_o` is low. A start pulse that arrives while busy has no effect on the algorithm or on the number of operations in the run.
- R2: The value of `algo_sel_i` selects the algorithm: 0 = March Y, 1 = March LR with solid backgrounds, 2 = March LR with two-bit backgrounds, 3 = March Y. March Y uses 4 elements and applies 8 operations per address, 3 of them writes. Its elements are: w0; up(r0,w1,r1); down(r1,w0,r0); up(r0).
- R3: March LR with solid backgrounds uses 6 elements and applies 16 operations per address, 7 of them writes. Its elements are: w0; down(r0,w1); up(r1,w0,r0,r0,w1); up(r1,w0); up(r0,w1,r1,r1,w0); up(r0).
- R4: The two-bit background variant keeps the first five March LR elements. It then runs three more: up(r00,w01,w10,r10); up(r10,w01,r01); up(r01). That gives 23 operations per address, 10 of them writes. The word types are:
  - Pattern 00: every bit 0.
  - Pattern 11: every bit 1.
  - Pattern 01: even bits 1 and odd bits 0.
  - Pattern 10: odd bits 1 and even bits 0.
  
  As a result, a fault that forces bits 0 and 1 of one word to their AND is detected in element 5.
- R5: An element marked up starts at address 0 and counts upward. An element marked down starts at address DEPTH-1 and counts downward. An element whose order is free runs upward.
- R6: While busy, the controller issues exactly one memory operation per clock, with no idle gaps. `busy_o` stays high for the number of operations plus one final compare cycle. `mem_we_o` is high only when `mem_en_o` is high.
- R7: The data on `mem_rdata_i` in the cycle after a read is compared with the expected word for that read. Any mismatch sets `fail_o`, which stays set. The address and the zero-based element index of the first mismatch are captured, and later mismatches do not change them.
- R8: `done_o` rises when the controller returns to idle at the end of a run. It stays high until the next accepted start. That start also clears `fail_o`, `fail_addr_o` and `fail_elem_o`. `done_o` is never high while `busy_o` is high.
- R9: A mismatch on the very last read of a run is reported. `fail_o` rises in the same cycle as `done_o`.
- R10: After reset the controller is idle. `mem_en_o`, `done_o` and `fail_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; taken only while idle |
| algo_sel_i | input | 2 | Algorithm code |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Write enable (read when low) |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, one cycle after the read |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Run finished; held until the next start |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_elem_o | output | 4 | Element index of the first mismatch |

## Verification
The compare of the final read happens in the extra cycle after the last operation. That is the same cycle in which the controller finishes the run and raises done. A second coincidence is the arrival of a new start pulse while a run is in progress.

To provoke the first case, the bench's RAM model corrupts only the last read of a March Y run. It then checks that fail and done rise together, and that the captured address and element are the top address and element 3.

To provoke the second case, a start pulse carrying a different algorithm code is driven in the middle of a run. The bench then checks that the operation and write counts still match the first algorithm.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int ELEM_W = 4;
  localparam int OPS_W  = 3;

  typedef enum logic [1:0] {BG_00, BG_11, BG_01, BG_10} bg_e;

  typedef struct packed {
    logic wr;
    bg_e  bg;
  } op_t;

  typedef struct packed {
    logic             down;
    logic [OPS_W-1:0] nops;
    op_t [4:0]        ops;
  } elem_t;

  function automatic op_t rd(bg_e b);
    op_t o;
    o.wr = 1'b0;
    o.bg = b;
    return o;
  endfunction

  function automatic op_t wr(bg_e b);
    op_t o;
    o.wr = 1'b1;
    o.bg = b;
    return o;
  endfunction

  function automatic elem_t mk(logic dn, logic [OPS_W-1:0] n,
                               op_t a, op_t b, op_t c, op_t d, op_t e);
    elem_t t;
    t.down   = dn;
    t.nops   = n;
    t.ops[0] = a;
    t.ops[1] = b;
    t.ops[2] = c;
    t.ops[3] = d;
    t.ops[4] = e;
    return t;
  endfunction

  function automatic logic [ELEM_W-1:0] elem_count(logic [1:0] algo);
    case (algo)
      2'd1:    return ELEM_W'(6);
      2'd2:    return ELEM_W'(8);
      default: return ELEM_W'(4);
    endcase
  endfunction

  // element table; "either" order is encoded as ascending
  function automatic elem_t elem_desc(logic [1:0] algo, logic [ELEM_W-1:0] idx);
    op_t z;
    elem_t r;
    z = rd(BG_00);
    r = mk(1'b0, 3'd1, wr(BG_00), z, z, z, z);
    if (algo == 2'd1 || algo == 2'd2) begin
      case (idx)
        4'd1: r = mk(1'b1, 3'd2, rd(BG_00), wr(BG_11), z, z, z);
        4'd2: r = mk(1'b0, 3'd5, rd(BG_11), wr(BG_00), rd(BG_00), rd(BG_00), wr(BG_11));
        4'd3: r = mk(1'b0, 3'd2, rd(BG_11), wr(BG_00), z, z, z);
        4'd4: r = mk(1'b0, 3'd5, rd(BG_00), wr(BG_11), rd(BG_11), rd(BG_11), wr(BG_00));
        4'd5: begin
          if (algo == 2'd2) r = mk(1'b0, 3'd4, rd(BG_00), wr(BG_01), wr(BG_10), rd(BG_10), z);
          else              r = mk(1'b0, 3'd1, rd(BG_00), z, z, z, z);
        end
        4'd6: r = mk(1'b0, 3'd3, rd(BG_10), wr(BG_01), rd(BG_01), z, z);
        4'd7: r = mk(1'b0, 3'd1, rd(BG_01), z, z, z, z);
        default: ;
      endcase
    end else begin
      case (idx)
        4'd1: r = mk(1'b0, 3'd3, rd(BG_00), wr(BG_11), rd(BG_11), z, z);
        4'd2: r = mk(1'b1, 3'd3, rd(BG_11), wr(BG_00), rd(BG_00), z, z);
        4'd3: r = mk(1'b0, 3'd1, rd(BG_00), z, z, z, z);
        default: ;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        algo_i,
  output logic              accept_o,
  output logic              issue_o,
  output op_t               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ELEM_W-1:0] elem_o,
  output logic              busy_o,
  output logic              fin_o
);

  localparam logic [ADDR_W-1:0] A_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FLUSH} st_e;

  st_e               st_q;
  logic [1:0]        algo_q;
  logic [ELEM_W-1:0] elem_q;
  logic [OPS_W-1:0]  op_q;
  logic [ADDR_W-1:0] addr_q;

  elem_t cur, nxt;
  logic  last_op, last_addr, last_elem;

  always_comb begin
    cur       = elem_desc(algo_q, elem_q);
    nxt       = elem_desc(algo_q, elem_q + ELEM_W'(1));
    last_op   = (op_q == cur.nops - OPS_W'(1));
    last_addr = cur.down ? (addr_q == '0) : (addr_q == A_MAX);
    last_elem = (elem_q == elem_count(algo_q) - ELEM_W'(1));
  end

  assign accept_o = (st_q == S_IDLE) && start_i;
  assign issue_o  = (st_q == S_RUN);
  assign op_o     = cur.ops[op_q];
  assign addr_o   = addr_q;
  assign elem_o   = elem_q;
  assign busy_o   = (st_q != S_IDLE);
  assign fin_o    = (st_q == S_FLUSH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      algo_q <= '0;
      elem_q <= '0;
      op_q   <= '0;
      addr_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          st_q   <= S_RUN;
          algo_q <= algo_i;
          elem_q <= '0;
          op_q   <= '0;
          addr_q <= elem_desc(algo_i, '0).down ? A_MAX : '0;
        end
        S_RUN: begin
          if (!last_op) begin
            op_q <= op_q + OPS_W'(1);
          end else begin
            op_q <= '0;
            if (!last_addr) begin
              addr_q <= cur.down ? addr_q - ADDR_W'(1) : addr_q + ADDR_W'(1);
            end else if (last_elem) begin
              st_q <= S_FLUSH;
            end else begin
              elem_q <= elem_q + ELEM_W'(1);
              addr_q <= nxt.down ? A_MAX : '0;
            end
          end
        end
        S_FLUSH: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbist_pattern.sv
module mbist_pattern
  import mbist_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  bg_e               bg_i,
  output logic [DATA_W-1:0] word_o
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam bit EVEN = (i % 2) == 0;
    assign word_o[i] = (bg_i == BG_11) |
                       ((bg_i == BG_01) & EVEN) |
                       ((bg_i == BG_10) & !EVEN);
  end

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [ELEM_W-1:0] fail_elem_o
);

  logic              vld_q;
  logic [DATA_W-1:0] exp_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ELEM_W-1:0] elem_q;
  logic              miss;

  // align expected word with the one-cycle read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      exp_q  <= '0;
      addr_q <= '0;
      elem_q <= '0;
    end else begin
      vld_q <= rd_i;
      if (rd_i) begin
        exp_q  <= exp_i;
        addr_q <= addr_i;
        elem_q <= elem_i;
      end
    end
  end

  assign miss = vld_q && (rdata_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
      fail_elem_o <= '0;
    end else if (clear_i) begin
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
      fail_elem_o <= '0;
    end else if (miss && !fail_o) begin
      fail_o      <= 1'b1;
      fail_addr_o <= addr_q;
      fail_elem_o <= elem_q;
    end
  end

endmodule

// File: rtl/mbist_march_ctrl.sv
module mbist_march_ctrl
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        algo_sel_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [ELEM_W-1:0] fail_elem_o
);

  logic              accept, issue, fin;
  op_t               op;
  logic [ADDR_W-1:0] addr;
  logic [ELEM_W-1:0] elem;
  logic [DATA_W-1:0] word;
  logic              done_q;

  mbist_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .algo_i   (algo_sel_i),
    .accept_o (accept),
    .issue_o  (issue),
    .op_o     (op),
    .addr_o   (addr),
    .elem_o   (elem),
    .busy_o   (busy_o),
    .fin_o    (fin)
  );

  mbist_pattern #(.DATA_W(DATA_W)) u_pat (
    .bg_i   (op.bg),
    .word_o (word)
  );

  mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (accept),
    .rd_i        (issue && !op.wr),
    .exp_i       (word),
    .addr_i      (addr),
    .elem_i      (elem),
    .rdata_i     (mem_rdata_i),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .fail_elem_o (fail_elem_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     done_q <= 1'b0;
    else if (accept) done_q <= 1'b0;
    else if (fin)    done_q <= 1'b1;
  end

  assign done_o      = done_q;
  assign mem_en_o    = issue;
  assign mem_we_o    = issue && op.wr;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = word;

endmodule

// File: rtl/mbist_march_ctrl_chk.sv
module mbist_march_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [ADDR_W-1:0] fail_addr_o,
  input logic [3:0]        fail_elem_o
);

  logic accept;
  assign accept = start_i && !busy_o;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_en_o);

  p_we_in_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_en_o);

  p_fail_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !accept |=> fail_o);

  p_capture_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !accept |=> $stable(fail_addr_o) && $stable(fail_elem_o));

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_end_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

endmodule

bind mbist_march_ctrl mbist_march_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/mbist_march_ctrl_tb.sv
`timescale 1ns/1ps
module mbist_march_ctrl_tb;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    algo_sel_i = '0;
  logic          mem_en_o, mem_we_o, busy_o, done_o, fail_o;
  logic [AW-1:0] mem_addr_o, fail_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i;
  logic [3:0]    fail_elem_o;

  always #2 clk_i = ~clk_i;

  mbist_march_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

  // RAM model with injectable faults
  logic [DW-1:0] mem [DEPTH];
  int            n_ops, n_wr, n_rd;
  logic [AW-1:0] first_rd_addr;
  logic          sa1_en = 0, sa0_en = 0, br_en = 0, flip_en = 0;
  logic [AW-1:0] f_addr = '0;
  logic [DW-1:0] f_mask = '0;
  int            flip_num = 0;

  function automatic logic [DW-1:0] faulty(logic [DW-1:0] v, logic [AW-1:0] a, int num);
    logic [DW-1:0] r;
    r = v;
    if (sa1_en && a == f_addr) r = r | f_mask;
    if (sa0_en && a == f_addr) r = r & ~f_mask;
    if (br_en && a == f_addr) begin
      r[0] = v[0] & v[1];
      r[1] = v[0] & v[1];
    end
    if (flip_en && num == flip_num) r = r ^ DW'(1);
    return r;
  endfunction

  always @(posedge clk_i) begin
    if (start_i && !busy_o) begin
      n_ops <= 0;
      n_wr  <= 0;
      n_rd  <= 0;
    end else if (mem_en_o) begin
      n_ops <= n_ops + 1;
      if (mem_we_o) begin
        mem[mem_addr_o] <= mem_wdata_o;
        n_wr <= n_wr + 1;
      end else begin
        if (n_rd == 0) first_rd_addr <= mem_addr_o;
        n_rd <= n_rd + 1;
        mem_rdata_i <= faulty(mem[mem_addr_o], mem_addr_o, n_rd + 1);
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  int busy_cyc;
  logic fail_prev, fail_at_done;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_faults();
    sa1_en = 0; sa0_en = 0; br_en = 0; flip_en = 0;
  endtask

  // start a run; optional stray start pulse (algo 2) 'mid' cycles in
  task automatic run(input logic [1:0] a, input int mid);
    int guard;
    @(negedge clk_i);
    start_i = 1'b1;
    algo_sel_i = a;
    @(negedge clk_i);
    start_i = 1'b0;
    busy_cyc = 0;
    fail_prev = 0;
    guard = 0;
    while (!done_o && guard < 3000) begin
      if (busy_o) busy_cyc++;
      fail_prev = fail_o;
      if (mid >= 0 && guard == mid) begin
        start_i = 1'b1;
        algo_sel_i = 2'd2;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      guard++;
    end
    start_i = 1'b0;
    fail_at_done = fail_o;
    if (guard >= 3000) check("R6 run completes", 0, 1);
  endtask

  task automatic t_reset();
    check("R10 busy after reset", busy_o, 0);
    check("R10 mem_en after reset", mem_en_o, 0);
    check("R10 done after reset", done_o, 0);
    check("R10 fail after reset", fail_o, 0);
  endtask

  task automatic t_march_y();
    run(2'd0, -1);
    check("R2 March Y ops", n_ops, 8 * DEPTH);
    check("R2 March Y writes", n_wr, 3 * DEPTH);
    check("R6 March Y busy cycles", busy_cyc, 8 * DEPTH + 1);
    check("R5 March Y first read addr", first_rd_addr, 0);
    check("R8 done after run", done_o, 1);
    check("R7 clean March Y", fail_o, 0);
  endtask

  task automatic t_march_lr();
    run(2'd1, -1);
    check("R3 LR ops", n_ops, 16 * DEPTH);
    check("R3 LR writes", n_wr, 7 * DEPTH);
    check("R6 LR busy cycles", busy_cyc, 16 * DEPTH + 1);
    check("R5 LR down element starts at top", first_rd_addr, DEPTH - 1);
    check("R7 clean LR", fail_o, 0);
  endtask

  task automatic t_march_bds();
    run(2'd2, -1);
    check("R4 BDS ops", n_ops, 23 * DEPTH);
    check("R4 BDS writes", n_wr, 10 * DEPTH);
    check("R4 BDS final word is pattern 01", mem[3], 8'h55);
    check("R7 clean BDS", fail_o, 0);
  endtask

  task automatic t_alias3();
    run(2'd3, -1);
    check("R2 code 3 ops", n_ops, 8 * DEPTH);
    check("R2 code 3 writes", n_wr, 3 * DEPTH);
  endtask

  task automatic t_start_ignored();
    run(2'd0, 20);
    check("R1 stray start ops", n_ops, 8 * DEPTH);
    check("R1 stray start writes", n_wr, 3 * DEPTH);
    check("R1 stray start busy", busy_cyc, 8 * DEPTH + 1);
  endtask

  task automatic t_sa0_y();
    sa0_en = 1; f_addr = 4'd9; f_mask = 8'h04;
    run(2'd0, -1);
    check("R7 SA0 fail", fail_o, 1);
    check("R7 SA0 addr", fail_addr_o, 9);
    check("R7 SA0 elem", fail_elem_o, 1);
    clear_faults();
  endtask

  task automatic t_sa1_lr();
    sa1_en = 1; f_addr = 4'd5; f_mask = 8'h01;
    run(2'd1, -1);
    check("R7 SA1 LR fail", fail_o, 1);
    check("R7 SA1 LR addr (first of many)", fail_addr_o, 5);
    check("R7 SA1 LR elem", fail_elem_o, 1);
    clear_faults();
  endtask

  task automatic t_bridge();
    br_en = 1; f_addr = 4'd7;
    run(2'd0, -1);
    check("R4 bridge missed by March Y", fail_o, 0);
    run(2'd1, -1);
    check("R4 bridge missed by LR", fail_o, 0);
    run(2'd2, -1);
    check("R4 bridge caught by BDS", fail_o, 1);
    check("R4 bridge addr", fail_addr_o, 7);
    check("R4 bridge elem", fail_elem_o, 5);
    clear_faults();
  endtask

  task automatic t_last_read();
    flip_en = 1; flip_num = 5 * DEPTH;
    run(2'd0, -1);
    check("R9 no fail before done", fail_prev, 0);
    check("R9 fail with done", fail_at_done, 1);
    check("R9 last read addr", fail_addr_o, DEPTH - 1);
    check("R9 last read elem", fail_elem_o, 3);
    clear_faults();
  endtask

  task automatic t_clear();
    @(negedge clk_i);
    start_i = 1'b1;
    algo_sel_i = 2'd0;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R8 done cleared by start", done_o, 0);
    check("R8 fail cleared by start", fail_o, 0);
    check("R8 busy after start", busy_o, 1);
    run(2'd0, -1);
    check("R8 clean rerun passes", fail_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_march_y();
    t_march_lr();
    t_march_bds();
    t_alias3();
    t_start_ignored();
    t_sa0_y();
    t_sa1_lr();
    t_bridge();
    t_last_read();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule